// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Slave

This block models a small serial nonvolatile memory that answers on a three-wire link: a select line, a serial clock and a data-in line, plus one data-out line that is only driven while the device is selected. The link is sampled in the system clock domain. Each input passes a short synchronizer, and serial clock edges are found from the synchronized level. A frame is a start bit, a two-bit command code and an address, MSB first. Write-type frames then carry a data word, also MSB first. The storage array is a bank of registers.

Programming is guarded in two ways. A write-enable latch must first be set by a dedicated command. The select line must also drop inside one narrow window, after the final frame bit and before the next serial clock rise. When both conditions hold, a self-timed cycle of a fixed number of system clocks begins. The array changes at the end of that cycle. While the cycle runs, a host that re-selects the device sees data-out low, and it sees data-out high once the cycle is over. Reads do not depend on the enable latch. A read returns a leading zero and then the stored word, one bit per serial clock rise.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the enable latch is clear, `doutEn` is 0 while `cs` is low, and every word of the array reads as all ones.
- R2: A frame begins with the first `di` = 1 sampled on an `sk` rise with `cs` high; zeros before it are ignored. Two code bits follow, then ADDR_W address bits MSB first. Codes: 10 read, 01 write, 11 erase, 00 special. For code 00 the two top address bits select 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R3: Write, erase, write-all and erase-all leave the array unchanged and start no busy cycle while the enable latch is clear. Enable sets the latch, disable clears it, and it holds until the next disable or reset.
- R4: After the last address bit of a read, `dout` is 0. Each of the next DATA_W `sk` rises presents the following stored bit, MSB first. Reads work with the latch set or clear.
- R5: A write takes DATA_W data bits MSB first after the address and stores them at that address.
- R6: An erase sets the addressed word to all ones.
- R7: Erase-all sets every word to all ones. Write-all stores its data word in every word, whatever the earlier contents.
- R8: A modifying frame starts only if `cs` is seen low after its last bit and before the next `sk` rise. If `cs` drops earlier, or an `sk` rise comes first, nothing changes. When both are seen in the same clock, the start wins.
- R9: The busy cycle lasts CYCLE_CLKS system clocks from the clock in which `cs` low is seen. `doutEn` follows the synchronized `cs`. While selected, `dout` is 0 during the busy cycle and 1 once ready.
- R10: Frames sent during a busy cycle have no effect on the array or on the enable latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Device select, active high |
| sk | input | 1 | Serial clock; data is taken on its rising edge |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out / ready-busy status |
| doutEn | output | 1 | Output enable for `dout`; low means high impedance |

## Verification
Two events can land in the same system clock: the select drop that opens a programming cycle, and the serial clock rise that closes the window for it. The bench provokes this by lowering `cs` and raising `sk` on the same clock step right after a write frame. Both inputs pass through equal synchronizer depth, so the controller sees them together. The result is judged by reading the word back, and the start must have won. The early-drop and late-drop cases around that tie are each judged the same way: the status read must show no busy cycle, and the word must be unchanged.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_ERASE = 2'd1,
    OP_WRALL = 2'd2,
    OP_ERALL = 2'd3
  } mod_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_DEC,
    ST_DAT,
    ST_ARM,
    ST_BUSY,
    ST_RD,
    ST_SKIP
  } ctrl_state_e;

  typedef struct packed {
    logic    shiftIn;
    logic    latchAddr;
    logic    loadRead;
    logic    shiftOut;
    logic    commit;
    mod_op_e op;
    logic    showBusy;
    logic    showRead;
  } dp_strobe_t;

endpackage

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int CYCLE_CLKS = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csS,
  input  logic       skRise,
  input  logic       diS,
  input  logic [1:0] addrTop,
  output dp_strobe_t stb,
  output logic       busy,
  output logic       wen
);

  localparam int MAXW = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CW   = $clog2(MAXW + 1);
  localparam int TW   = $clog2(CYCLE_CLKS + 1);

  ctrl_state_e     state;
  logic [1:0]      opc;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   timer;
  mod_op_e         pend;

  assign busy = (state == ST_BUSY);

  always_comb begin
    stb           = '0;
    stb.op        = pend;
    stb.shiftIn   = csS && skRise && (state == ST_ADR || state == ST_DAT);
    stb.latchAddr = (state == ST_DEC);
    stb.loadRead  = (state == ST_DEC) && (opc == 2'b10);
    stb.shiftOut  = (state == ST_RD) && csS && skRise && (cnt != CW'(DATA_W));
    stb.commit    = (state == ST_BUSY) && (timer == '0);
    stb.showBusy  = (state == ST_BUSY);
    stb.showRead  = (state == ST_RD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      opc   <= '0;
      cnt   <= '0;
      timer <= '0;
      pend  <= OP_WRITE;
      wen   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (csS && skRise && diS) begin
            state <= ST_OPC;
            cnt   <= '0;
          end
        end
        ST_OPC: begin
          if (!csS) state <= ST_IDLE;
          else if (skRise) begin
            opc <= {opc[0], diS};
            if (cnt == CW'(1)) begin
              state <= ST_ADR;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
        end
        ST_ADR: begin
          if (!csS) state <= ST_IDLE;
          else if (skRise) begin
            if (cnt == CW'(ADDR_W - 1)) state <= ST_DEC;
            else cnt <= cnt + 1'b1;
          end
        end
        ST_DEC: begin
          cnt <= '0;
          case (opc)
            2'b10: state <= ST_RD;
            2'b01: begin
              pend  <= OP_WRITE;
              state <= wen ? ST_DAT : ST_SKIP;
            end
            2'b11: begin
              pend  <= OP_ERASE;
              state <= wen ? ST_ARM : ST_SKIP;
            end
            default: begin
              case (addrTop)
                2'b10: begin
                  pend  <= OP_ERALL;
                  state <= wen ? ST_ARM : ST_SKIP;
                end
                2'b01: begin
                  pend  <= OP_WRALL;
                  state <= wen ? ST_DAT : ST_SKIP;
                end
                2'b11: begin
                  wen   <= 1'b1;
                  state <= ST_SKIP;
                end
                default: begin
                  wen   <= 1'b0;
                  state <= ST_SKIP;
                end
              endcase
            end
          endcase
        end
        ST_DAT: begin
          if (!csS) state <= ST_IDLE;
          else if (skRise) begin
            if (cnt == CW'(DATA_W - 1)) state <= ST_ARM;
            else cnt <= cnt + 1'b1;
          end
        end
        ST_ARM: begin
          // select low takes priority over a simultaneous clock rise
          if (!csS) begin
            state <= ST_BUSY;
            timer <= TW'(CYCLE_CLKS - 1);
          end else if (skRise) state <= ST_SKIP;
        end
        ST_BUSY: begin
          if (timer == '0) state <= ST_IDLE;
          else timer <= timer - 1'b1;
        end
        ST_RD: begin
          if (!csS) state <= ST_IDLE;
          else if (skRise) begin
            if (cnt == CW'(DATA_W)) state <= ST_SKIP;
            else cnt <= cnt + 1'b1;
          end
        end
        ST_SKIP: begin
          if (!csS) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mw_datapath.sv
module mw_datapath
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             diS,
  input  dp_strobe_t       stb,
  output logic [1:0]       addrTop,
  output logic             dout
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SRW   = ADDR_W + DATA_W;

  logic [SRW-1:0]    inSr;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] rdSr;
  logic              rdBit;
  logic [DATA_W-1:0] mem [DEPTH];

  assign addrTop = inSr[ADDR_W-1 -: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inSr  <= '0;
      addrQ <= '0;
      rdSr  <= '0;
      rdBit <= 1'b0;
    end else begin
      if (stb.shiftIn)   inSr  <= {inSr[SRW-2:0], diS};
      if (stb.latchAddr) addrQ <= inSr[ADDR_W-1:0];
      if (stb.loadRead) begin
        rdSr  <= mem[inSr[ADDR_W-1:0]];
        rdBit <= 1'b0;
      end else if (stb.shiftOut) begin
        rdBit <= rdSr[DATA_W-1];
        rdSr  <= {rdSr[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (stb.commit) begin
      for (int i = 0; i < DEPTH; i++) begin
        unique case (stb.op)
          OP_WRITE: if (addrQ == ADDR_W'(i)) mem[i] <= inSr[DATA_W-1:0];
          OP_ERASE: if (addrQ == ADDR_W'(i)) mem[i] <= '1;
          OP_WRALL: mem[i] <= inSr[DATA_W-1:0];
          OP_ERALL: mem[i] <= '1;
        endcase
      end
    end
  end

  assign dout = stb.showBusy ? 1'b0 : (stb.showRead ? rdBit : 1'b1);

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int CYCLE_CLKS  = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout,
  output logic doutEn
);

  logic       csS, skS, diS, skQ, skRise;
  logic       busy, wen;
  logic [1:0] addrTop;
  dp_strobe_t stb;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign csS = cs;
      assign skS = sk;
      assign diS = di;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] csP, skP, diP;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          csP <= '0;
          skP <= '0;
          diP <= '0;
        end else begin
          csP <= {csP[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], cs} >> ((SYNC_STAGES == 1) ? 1 : 0);
          skP <= {skP[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], sk} >> ((SYNC_STAGES == 1) ? 1 : 0);
          diP <= {diP[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], di} >> ((SYNC_STAGES == 1) ? 1 : 0);
        end
      end
      assign csS = csP[SYNC_STAGES-1];
      assign skS = skP[SYNC_STAGES-1];
      assign diS = diP[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skQ <= 1'b0;
    else        skQ <= skS;
  end
  assign skRise = skS & ~skQ;

  mw_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CYCLE_CLKS(CYCLE_CLKS)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .csS    (csS),
    .skRise (skRise),
    .diS    (diS),
    .addrTop(addrTop),
    .stb    (stb),
    .busy   (busy),
    .wen    (wen)
  );

  mw_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .diS    (diS),
    .stb    (stb),
    .addrTop(addrTop),
    .dout   (dout)
  );

  assign doutEn = csS;

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
  parameter int CYCLE_CLKS = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic csS,
  input logic busy,
  input logic wen,
  input logic commit,
  input logic dout,
  input logic doutEn
);

  int busyCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busyCnt <= 0;
    else if (busy) busyCnt <= busyCnt + 1;
    else           busyCnt <= 0;
  end

  a_r9_busy_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    busy && doutEn |-> !dout);

  a_r3_commit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> wen);

  a_r8_start_on_select_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !csS);

  a_r9_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busyCnt == CYCLE_CLKS);

  a_r10_latch_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(wen));

endmodule

bind mw_eeprom mw_eeprom_chk #(.CYCLE_CLKS(CYCLE_CLKS)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .csS   (csS),
  .busy  (busy),
  .wen   (wen),
  .commit(stb.commit),
  .dout  (dout),
  .doutEn(doutEn)
);

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int CYC    = 600;
  localparam int HALF   = 8;

  localparam logic [2:0] K_RD = 3'd0, K_WR = 3'd1, K_ER = 3'd2, K_WRAL = 3'd3,
                         K_ERAL = 3'd4, K_EN = 3'd5, K_DIS = 3'd6;
  localparam logic [1:0] M_OK = 2'd0, M_EARLY = 2'd1, M_LATE = 2'd2, M_TIE = 2'd3;

  typedef struct packed {
    logic [2:0]  kind;
    logic [5:0]  addr;
    logic [15:0] data;
    logic [1:0]  mode;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{K_RD,   6'd5,  16'h0000, M_OK,    4'd1},  // R1 reset contents
    '{K_WR,   6'd5,  16'h1234, M_OK,    4'd3},  // R3 disabled write
    '{K_RD,   6'd5,  16'h0000, M_OK,    4'd3},
    '{K_EN,   6'd0,  16'h0000, M_OK,    4'd3},
    '{K_WR,   6'd5,  16'hA5C3, M_OK,    4'd5},  // R5
    '{K_RD,   6'd5,  16'h0000, M_OK,    4'd5},
    '{K_WR,   6'd6,  16'h0F0F, M_EARLY, 4'd8},  // R8 early drop
    '{K_RD,   6'd6,  16'h0000, M_OK,    4'd8},
    '{K_WR,   6'd7,  16'h3C3C, M_LATE,  4'd8},  // R8 late drop
    '{K_RD,   6'd7,  16'h0000, M_OK,    4'd8},
    '{K_WR,   6'd8,  16'h7E81, M_TIE,   4'd8},  // R8 same-clock tie
    '{K_RD,   6'd8,  16'h0000, M_OK,    4'd8},
    '{K_ER,   6'd5,  16'h0000, M_OK,    4'd6},  // R6
    '{K_RD,   6'd5,  16'h0000, M_OK,    4'd6},
    '{K_WRAL, 6'd0,  16'h5AA5, M_OK,    4'd7},  // R7 write-all
    '{K_RD,   6'd0,  16'h0000, M_OK,    4'd7},
    '{K_RD,   6'd63, 16'h0000, M_OK,    4'd7},
    '{K_WR,   6'd9,  16'h0001, M_OK,    4'd5},
    '{K_RD,   6'd9,  16'h0000, M_OK,    4'd5},
    '{K_ERAL, 6'd0,  16'h0000, M_OK,    4'd7},  // R7 erase-all
    '{K_RD,   6'd9,  16'h0000, M_OK,    4'd7},
    '{K_RD,   6'd40, 16'h0000, M_OK,    4'd7},
    '{K_DIS,  6'd0,  16'h0000, M_OK,    4'd3},
    '{K_WR,   6'd10, 16'h0000, M_OK,    4'd3},
    '{K_RD,   6'd10, 16'h0000, M_OK,    4'd4},  // R4 read while disabled
    '{K_EN,   6'd0,  16'h0000, M_OK,    4'd3},
    '{K_WR,   6'd63, 16'h8000, M_OK,    4'd5},
    '{K_RD,   6'd63, 16'h0000, M_OK,    4'd5},
    '{K_ER,   6'd63, 16'h0000, M_EARLY, 4'd8},
    '{K_RD,   6'd63, 16'h0000, M_OK,    4'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, doutEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] model [1 << ADDR_W];
  bit modelWen = 1'b0;

  always #2 clk = ~clk;

  mw_eeprom #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYCLE_CLKS(CYC), .SYNC_STAGES(2)
  ) i_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .dout(dout), .doutEn(doutEn)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    di = b;
    waitClk(HALF);
    sk = 1'b1;
    waitClk(HALF);
    sk = 1'b0;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  task automatic buildFrame(input logic [2:0] kind, input logic [5:0] addr, input logic [15:0] data,
                            output logic [31:0] v, output int n);
    case (kind)
      K_RD:    begin v = {23'd0, 3'b110, addr};         n = 9;  end
      K_WR:    begin v = {7'd0, 3'b101, addr, data};    n = 25; end
      K_ER:    begin v = {23'd0, 3'b111, addr};         n = 9;  end
      K_WRAL:  begin v = {7'd0, 3'b100, 6'b010000, data}; n = 25; end
      K_ERAL:  begin v = {23'd0, 3'b100, 6'b100000};    n = 9;  end
      K_EN:    begin v = {23'd0, 3'b100, 6'b110000};    n = 9;  end
      default: begin v = {23'd0, 3'b100, 6'b000000};    n = 9;  end
    endcase
  endtask

  task automatic readWord(input logic [5:0] addr, input int lead, input string tag,
                          output logic [DATA_W-1:0] w);
    logic [31:0] v;
    int n;
    buildFrame(K_RD, addr, 16'h0, v, n);
    cs = 1'b1;
    waitClk(HALF);
    for (int i = 0; i < lead; i++) pulse(1'b0);
    sendBits(v, n);
    waitClk(HALF);
    check(dout === 1'b0, "R4 dummy bit", {31'd0, dout}, 32'd0);
    for (int i = DATA_W - 1; i >= 0; i--) begin
      di = 1'b0;
      waitClk(HALF);
      sk = 1'b1;
      waitClk(HALF - 1);
      w[i] = dout;
      waitClk(1);
      sk = 1'b0;
    end
    waitClk(HALF);
    cs = 1'b0;
    waitClk(HALF);
  endtask

  task automatic waitReady();
    waitClk(4);
    cs = 1'b1;
    waitClk(8);
    check(doutEn === 1'b1, "R9 enable follows select", {31'd0, doutEn}, 32'd1);
    check(dout === 1'b0, "R9 busy low", {31'd0, dout}, 32'd0);
    waitClk(CYC + 20);
    check(dout === 1'b1, "R9 ready high", {31'd0, dout}, 32'd1);
    cs = 1'b0;
    waitClk(HALF);
  endtask

  task automatic applyVec(input vec_t t);
    logic [31:0] v;
    int n;
    logic [DATA_W-1:0] w;
    bit starts;
    string tag;
    tag = $sformatf("R%0d", t.req);
    if (t.kind == K_RD) begin
      readWord(t.addr, 0, tag, w);
      check(w === model[t.addr], {tag, " read data"}, {16'd0, w}, {16'd0, model[t.addr]});
      return;
    end
    buildFrame(t.kind, t.addr, t.data, v, n);
    cs = 1'b1;
    waitClk(HALF);
    case (t.mode)
      M_EARLY: begin sendBits(v >> 1, n - 1); cs = 1'b0; end
      M_LATE:  begin sendBits(v, n); pulse(1'b0); cs = 1'b0; end
      M_TIE:   begin sendBits(v, n); waitClk(HALF); sk = 1'b1; cs = 1'b0; waitClk(HALF); sk = 1'b0; end
      default: begin sendBits(v, n); waitClk(4); cs = 1'b0; end
    endcase
    starts = modelWen && (t.mode == M_OK || t.mode == M_TIE) &&
             (t.kind == K_WR || t.kind == K_ER || t.kind == K_WRAL || t.kind == K_ERAL);
    if (t.kind == K_EN)  modelWen = 1'b1;
    if (t.kind == K_DIS) modelWen = 1'b0;
    if (starts) begin
      case (t.kind)
        K_WR:    model[t.addr] = t.data;
        K_ER:    model[t.addr] = '1;
        K_WRAL:  for (int i = 0; i < (1 << ADDR_W); i++) model[i] = t.data;
        default: for (int i = 0; i < (1 << ADDR_W); i++) model[i] = '1;
      endcase
      waitReady();
    end else begin
      waitClk(HALF);
      cs = 1'b1;
      waitClk(HALF);
      check(dout === 1'b1, {tag, " no busy cycle"}, {31'd0, dout}, 32'd1);
      cs = 1'b0;
      waitClk(HALF);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [DATA_W-1:0] w;
    logic [31:0] v;
    int n;
    for (int i = 0; i < (1 << ADDR_W); i++) model[i] = '1;
    waitClk(5);
    rst_n = 1'b1;
    waitClk(5);
    // R1: deselected output is released after reset
    check(doutEn === 1'b0, "R1 output released", {31'd0, doutEn}, 32'd0);

    for (int k = 0; k < NV; k++) applyVec(VECS[k]);

    // R2: leading zeros before the start bit are ignored
    readWord(6'd63, 3, "R2", w);
    check(w === model[63], "R2 leading zeros", {16'd0, w}, {16'd0, model[63]});

    // R10: a full write frame sent while busy is ignored
    buildFrame(K_WR, 6'd3, 16'h1234, v, n);
    cs = 1'b1;
    waitClk(HALF);
    sendBits(v, n);
    waitClk(4);
    cs = 1'b0;
    model[3] = 16'h1234;
    waitClk(4);
    cs = 1'b1;
    waitClk(4);
    check(dout === 1'b0, "R10 busy during ignored frame", {31'd0, dout}, 32'd0);
    buildFrame(K_WR, 6'd3, 16'h0000, v, n);
    sendBits(v, n);
    waitClk(4);
    cs = 1'b0;
    waitClk(CYC);
    cs = 1'b1;
    waitClk(HALF);
    check(dout === 1'b1, "R10 ready after cycle", {31'd0, dout}, 32'd1);
    cs = 1'b0;
    waitClk(HALF);
    readWord(6'd3, 0, "R10", w);
    check(w === 16'h1234, "R10 word unchanged by busy frame", {16'd0, w}, 32'h1234);

    // R3: enable latch still set after the ignored frame, write goes through
    applyVec('{K_WR, 6'd4, 16'hBEEF, M_OK, 4'd3});
    readWord(6'd4, 0, "R3", w);
    check(w === 16'hBEEF, "R3 latch persists", {16'd0, w}, 32'hBEEF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule